// File: doc/BRIEF.md
# Commit-Point Trap Controller

This block decides, at the memory stage of a five-stage in-order pipeline, whether the instruction about to retire commits or traps. Fault flags raised in fetch, decode, execute or memory travel alongside their instruction inside the block's own tracking registers. A fault raised in an earlier stage keeps its cause code even when later stages add more faults. When the instruction reaches the memory stage, any pending external interrupt line is folded in and takes precedence over a synchronous fault.

On a trap the block suppresses the retiring instruction's writeback and kills every younger stage. It redirects fetch to a fixed handler address, latches the cause code and the exception PC, and clears the interrupt enable. A return request on the retiring instruction restores the enable and steers fetch back to the saved exception PC.

A two-state machine tracks the interrupt enable:
- ST_USER_RUN: interrupts are enabled. This is the state after reset.
- ST_IN_HANDLER: interrupts are disabled.

It has three transitions:
- TAKE_TRAP goes from ST_USER_RUN to ST_IN_HANDLER.
- NESTED_FAULT goes from ST_IN_HANDLER to ST_IN_HANDLER. A synchronous fault inside the handler overwrites the cause and EPC.
- RETURN goes from ST_IN_HANDLER to ST_USER_RUN. A return taken while already in ST_USER_RUN keeps that state.

Top module: `trap_commit_unit`

## Requirements
- R1: After reset, `irq_enable` is 1, `trap_cause` and `trap_epc` are 0, and `redirect_valid`, `kill_stage` and `wb_commit` are all low.
- R2: The instruction presented with `f_valid` in cycle t reaches the commit decision in cycle t+3. The per-stage fault inputs apply to it as follows: `d_*` in t+1, `e_*` in t+2, `m_*` in t+3.
- R3: When one instruction has faults from several stages, the cause reported is the one from the earliest stage (fetch before decode before execute before memory).
- R4: An external interrupt is taken when three conditions hold: `irq_enable` is 1, some `irq_lines` bit is high, and a valid instruction is at commit. It overrides any synchronous fault and records cause 15 (all ones) with EPC equal to that instruction's PC. Stage cause codes are always below 15.
- R5: Interrupt lines have no effect while `irq_enable` is 0 or while no valid instruction is at commit. The instruction commits normally and the cause and EPC are unchanged.
- R6: In a trap cycle `kill_stage` is 4'b1111, `redirect_valid` is 1, `redirect_pc` equals HANDLER_PC and `wb_commit` is 0. Bit 0 kills fetch, bit 1 decode, bit 2 execute and bit 3 the retiring result. `trap_cause` and `trap_epc` show the new values one cycle later.
- R7: For a synchronous fault `trap_epc` is the faulting instruction's PC. For a system call (cause 8) it is that PC plus 4.
- R8: `irq_enable` reads 0 in the cycle after any trap.
- R9: A return request with a valid, non-trapping instruction at commit has these effects in the same cycle: `redirect_valid` is 1, `redirect_pc` equals `trap_epc`, `kill_stage` is 4'b0111 and `wb_commit` is 1. `irq_enable` reads 1 the next cycle.
- R10: When a trap and a return request coincide, the trap wins: R6 and R8 apply and the return is dropped.
- R11: Instructions in fetch, decode or execute when a trap or return is taken never commit and never trap later.
- R12: A valid instruction with no fault and no taken interrupt asserts `wb_commit` in its commit cycle with `kill_stage` 0. A commit cycle with no valid instruction asserts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | N_IRQ | External interrupt requests |
| f_valid | input | 1 | Instruction present in fetch |
| f_pc | input | XLEN | PC of the fetch-stage instruction |
| f_exc | input | 1 | Fetch-address fault |
| f_cause | input | CAUSE_W | Cause code for the fetch fault |
| d_exc | input | 1 | Decode fault (illegal opcode or system call) |
| d_cause | input | CAUSE_W | Cause code for the decode fault |
| e_exc | input | 1 | Execute fault (overflow) |
| e_cause | input | CAUSE_W | Cause code for the execute fault |
| m_exc | input | 1 | Memory-stage data-address fault |
| m_cause | input | CAUSE_W | Cause code for the memory fault |
| ret_req | input | 1 | Retiring instruction is a return-from-exception |
| redirect_valid | output | 1 | Fetch must restart at `redirect_pc` |
| redirect_pc | output | XLEN | Restart address |
| kill_stage | output | 4 | Kill per stage: F, D, E, retiring result |
| wb_commit | output | 1 | Retiring instruction may write state |
| trap_cause | output | CAUSE_W | Latched cause of the last trap |
| trap_epc | output | XLEN | Latched exception PC |
| irq_enable | output | 1 | Interrupt enable |

## Verification
`redirect_valid`, `redirect_pc`, `kill_stage` and `wb_commit` respond combinationally in the cycle the instruction sits at commit. That is three clock edges after it was presented at fetch. `trap_cause`, `trap_epc` and `irq_enable` change at the edge that ends that cycle. The bench drives all inputs just after the falling edge and compares one time unit later against a stage-by-stage expectation model. Combinational outputs are therefore checked against the current commit cycle and registered outputs against the state left by the preceding edge. Directed sequences cover the corners: multiple faults on one instruction, a system call, an interrupt while disabled, and a trap coinciding with a return.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] CODE_FETCH_ADDR = 4'd0;
    localparam logic [CODE_W-1:0] CODE_ILLEGAL    = 4'd2;
    localparam logic [CODE_W-1:0] CODE_DATA_ADDR  = 4'd5;
    localparam logic [CODE_W-1:0] CODE_SYSCALL    = 4'd8;
    localparam logic [CODE_W-1:0] CODE_OVERFLOW   = 4'd12;
    localparam logic [CODE_W-1:0] CODE_EXT_IRQ    = 4'd15;

    typedef enum logic [0:0] {
        ST_USER_RUN   = 1'b0,
        ST_IN_HANDLER = 1'b1
    } trap_state_e;
endpackage

// File: rtl/exc_carry_stage.sv
module exc_carry_stage #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               up_valid,
    input  logic               up_exc,
    input  logic [CAUSE_W-1:0] up_cause,
    input  logic [XLEN-1:0]    up_pc,
    input  logic               loc_exc,
    input  logic [CAUSE_W-1:0] loc_cause,
    output logic               eff_valid,
    output logic               eff_exc,
    output logic [CAUSE_W-1:0] eff_cause,
    output logic [XLEN-1:0]    eff_pc
);
    logic               q_valid;
    logic               q_exc;
    logic [CAUSE_W-1:0] q_cause;
    logic [XLEN-1:0]    q_pc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_exc   <= 1'b0;
            q_cause <= '0;
            q_pc    <= '0;
        end else begin
            q_valid <= up_valid & ~flush;
            q_exc   <= up_exc & up_valid & ~flush;
            q_cause <= up_cause;
            q_pc    <= up_pc;
        end
    end

    // An older fault keeps its cause; this stage only adds one if none is held.
    always_comb begin
        eff_valid = q_valid;
        eff_pc    = q_pc;
        eff_exc   = q_exc | (q_valid & loc_exc);
        eff_cause = q_exc ? q_cause : loc_cause;
    end
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 4,
    parameter int N_IRQ   = 4
) (
    input  logic               c_valid,
    input  logic               c_exc,
    input  logic [CAUSE_W-1:0] c_cause,
    input  logic [XLEN-1:0]    c_pc,
    input  logic [N_IRQ-1:0]   irq_lines,
    input  logic               irq_en,
    input  logic               ret_req,
    output logic               take_trap,
    output logic               take_ret,
    output logic [CAUSE_W-1:0] new_cause,
    output logic [XLEN-1:0]    new_epc
);
    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

    logic irq_hit;
    logic is_syscall;

    always_comb begin
        irq_hit    = irq_en & c_valid & (|irq_lines);
        take_trap  = c_valid & (irq_hit | c_exc);
        take_ret   = c_valid & ret_req & ~take_trap;
        is_syscall = ~irq_hit & (c_cause == CAUSE_W'(CODE_SYSCALL));
        new_cause  = irq_hit ? CAUSE_W'(CODE_EXT_IRQ) : c_cause;
        new_epc    = is_syscall ? (c_pc + INSN_BYTES) : c_pc;
    end
endmodule

// File: rtl/trap_ctrl_fsm.sv
module trap_ctrl_fsm
    import trap_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          CAUSE_W    = 4,
    parameter logic [31:0] HANDLER_PC = 32'h0000_0080,
    parameter int          KILL_W     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               c_valid,
    input  logic               take_trap,
    input  logic               take_ret,
    input  logic [CAUSE_W-1:0] new_cause,
    input  logic [XLEN-1:0]    new_epc,
    output logic               irq_en,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc,
    output logic [KILL_W-1:0]  kill_stage,
    output logic               wb_commit,
    output logic [CAUSE_W-1:0] cause_q,
    output logic [XLEN-1:0]    epc_q
);
    localparam logic [KILL_W-1:0] KILL_ALL     = {KILL_W{1'b1}};
    localparam logic [KILL_W-1:0] KILL_YOUNGER = {1'b0, {(KILL_W-1){1'b1}}};

    trap_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_USER_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= '0;
            epc_q   <= '0;
        end else if (take_trap) begin
            cause_q <= new_cause;
            epc_q   <= new_epc;
        end
    end

    always_comb begin
        state_d        = state_q;
        irq_en         = 1'b0;
        redirect_valid = 1'b0;
        redirect_pc    = epc_q;
        kill_stage     = '0;
        wb_commit      = c_valid & ~take_trap;
        unique case (state_q)
            ST_USER_RUN: begin
                irq_en = 1'b1;
                if (take_trap) state_d = ST_IN_HANDLER;   // TAKE_TRAP
            end
            ST_IN_HANDLER: begin
                if (take_trap)     state_d = ST_IN_HANDLER; // NESTED_FAULT
                else if (take_ret) state_d = ST_USER_RUN;   // RETURN
            end
            default: state_d = ST_USER_RUN;
        endcase
        if (take_trap) begin
            redirect_valid = 1'b1;
            redirect_pc    = XLEN'(HANDLER_PC);
            kill_stage     = KILL_ALL;
        end else if (take_ret) begin
            redirect_valid = 1'b1;
            redirect_pc    = epc_q;
            kill_stage     = KILL_YOUNGER;
            state_d        = ST_USER_RUN;
        end
    end
endmodule

// File: rtl/trap_commit_unit.sv
module trap_commit_unit
    import trap_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          CAUSE_W    = 4,
    parameter int          N_IRQ      = 4,
    parameter logic [31:0] HANDLER_PC = 32'h0000_0080
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_IRQ-1:0]   irq_lines,
    input  logic               f_valid,
    input  logic [XLEN-1:0]    f_pc,
    input  logic               f_exc,
    input  logic [CAUSE_W-1:0] f_cause,
    input  logic               d_exc,
    input  logic [CAUSE_W-1:0] d_cause,
    input  logic               e_exc,
    input  logic [CAUSE_W-1:0] e_cause,
    input  logic               m_exc,
    input  logic [CAUSE_W-1:0] m_cause,
    input  logic               ret_req,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc,
    output logic [3:0]         kill_stage,
    output logic               wb_commit,
    output logic [CAUSE_W-1:0] trap_cause,
    output logic [XLEN-1:0]    trap_epc,
    output logic               irq_enable
);
    localparam int N_STAGE = 4;          // fetch, decode, execute, memory
    localparam int COMMIT  = N_STAGE - 1;

    logic               st_valid [N_STAGE];
    logic               st_exc   [N_STAGE];
    logic [CAUSE_W-1:0] st_cause [N_STAGE];
    logic [XLEN-1:0]    st_pc    [N_STAGE];
    logic               loc_exc  [N_STAGE];
    logic [CAUSE_W-1:0] loc_cause[N_STAGE];

    logic               take_trap;
    logic               take_ret;
    logic               flush;
    logic [CAUSE_W-1:0] new_cause;
    logic [XLEN-1:0]    new_epc;

    always_comb begin
        loc_exc[0]   = f_exc;    loc_cause[0] = f_cause;
        loc_exc[1]   = d_exc;    loc_cause[1] = d_cause;
        loc_exc[2]   = e_exc;    loc_cause[2] = e_cause;
        loc_exc[3]   = m_exc;    loc_cause[3] = m_cause;
        st_valid[0]  = f_valid;
        st_exc[0]    = f_valid & loc_exc[0];
        st_cause[0]  = loc_cause[0];
        st_pc[0]     = f_pc;
        flush        = take_trap | take_ret;
    end

    for (genvar g = 1; g < N_STAGE; g++) begin : g_carry
        exc_carry_stage #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .up_valid (st_valid[g-1]),
            .up_exc   (st_exc[g-1]),
            .up_cause (st_cause[g-1]),
            .up_pc    (st_pc[g-1]),
            .loc_exc  (loc_exc[g]),
            .loc_cause(loc_cause[g]),
            .eff_valid(st_valid[g]),
            .eff_exc  (st_exc[g]),
            .eff_cause(st_cause[g]),
            .eff_pc   (st_pc[g])
        );
    end

    trap_arbiter #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .N_IRQ(N_IRQ)) u_arb (
        .c_valid  (st_valid[COMMIT]),
        .c_exc    (st_exc[COMMIT]),
        .c_cause  (st_cause[COMMIT]),
        .c_pc     (st_pc[COMMIT]),
        .irq_lines(irq_lines),
        .irq_en   (irq_enable),
        .ret_req  (ret_req),
        .take_trap(take_trap),
        .take_ret (take_ret),
        .new_cause(new_cause),
        .new_epc  (new_epc)
    );

    trap_ctrl_fsm #(
        .XLEN(XLEN), .CAUSE_W(CAUSE_W), .HANDLER_PC(HANDLER_PC), .KILL_W(N_STAGE)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .c_valid       (st_valid[COMMIT]),
        .take_trap     (take_trap),
        .take_ret      (take_ret),
        .new_cause     (new_cause),
        .new_epc       (new_epc),
        .irq_en        (irq_enable),
        .redirect_valid(redirect_valid),
        .redirect_pc   (redirect_pc),
        .kill_stage    (kill_stage),
        .wb_commit     (wb_commit),
        .cause_q       (trap_cause),
        .epc_q         (trap_epc)
    );
endmodule

// File: rtl/trap_commit_unit_chk.sv
module trap_commit_unit_chk #(
    parameter int          XLEN       = 32,
    parameter int          CAUSE_W    = 4,
    parameter int          N_IRQ      = 4,
    parameter logic [31:0] HANDLER_PC = 32'h0000_0080
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_IRQ-1:0]   irq_lines,
    input logic               ret_req,
    input logic               redirect_valid,
    input logic [XLEN-1:0]    redirect_pc,
    input logic [3:0]         kill_stage,
    input logic               wb_commit,
    input logic [CAUSE_W-1:0] trap_cause,
    input logic [XLEN-1:0]    trap_epc,
    input logic               irq_enable
);
    localparam logic [CAUSE_W-1:0] IRQ_CODE = {CAUSE_W{1'b1}};

    a_r6_trap_kills_all: assert property (@(posedge clk) disable iff (!rst_n)
        kill_stage[3] |-> (kill_stage == 4'hF && redirect_valid && !wb_commit
                           && redirect_pc == XLEN'(HANDLER_PC)));

    a_r8_trap_disables_irq: assert property (@(posedge clk) disable iff (!rst_n)
        kill_stage[3] |=> !irq_enable);

    a_r9_return_target: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && !kill_stage[3]) |-> (redirect_pc == trap_epc
                                                && kill_stage == 4'h7 && wb_commit));

    a_r9_return_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && !kill_stage[3]) |=> irq_enable);

    a_r4_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_stage[3] && irq_enable && (|irq_lines)) |=> trap_cause == IRQ_CODE);

    a_r5_masked_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_stage[3] && !irq_enable) |=> trap_cause != IRQ_CODE);

    a_r10_trap_beats_return: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_stage[3] && ret_req) |=> !irq_enable);

    a_r6_state_held: assert property (@(posedge clk) disable iff (!rst_n)
        !kill_stage[3] |=> ($stable(trap_cause) && $stable(trap_epc)));
endmodule

bind trap_commit_unit trap_commit_unit_chk #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .N_IRQ(N_IRQ), .HANDLER_PC(HANDLER_PC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_lines     (irq_lines),
    .ret_req       (ret_req),
    .redirect_valid(redirect_valid),
    .redirect_pc   (redirect_pc),
    .kill_stage    (kill_stage),
    .wb_commit     (wb_commit),
    .trap_cause    (trap_cause),
    .trap_epc      (trap_epc),
    .irq_enable    (irq_enable)
);

// File: tb/trap_commit_unit_tb.sv
module trap_commit_unit_tb;
    localparam int          CLK_PERIOD = 10;
    localparam int          XLEN       = 32;
    localparam int          CW         = 4;
    localparam int          NI         = 4;
    localparam logic [31:0] HPC        = 32'h0000_0080;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NI-1:0] irq_lines = '0;
    logic f_valid = 1'b0, f_exc = 1'b0, d_exc = 1'b0, e_exc = 1'b0, m_exc = 1'b0, ret_req = 1'b0;
    logic [XLEN-1:0] f_pc = '0;
    logic [CW-1:0] f_cause = '0, d_cause = '0, e_cause = '0, m_cause = '0;
    logic redirect_valid, wb_commit, irq_enable;
    logic [XLEN-1:0] redirect_pc, trap_epc;
    logic [3:0] kill_stage;
    logic [CW-1:0] trap_cause;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // bench expectation state (stages 1..3 = D, E, M)
    bit              mv  [1:3];
    bit              mx  [1:3];
    logic [CW-1:0]   mc  [1:3];
    logic [XLEN-1:0] mp  [1:3];
    bit              ien = 1'b1;
    logic [CW-1:0]   cq  = '0;
    logic [XLEN-1:0] eq  = '0;

    trap_commit_unit #(.XLEN(XLEN), .CAUSE_W(CW), .N_IRQ(NI), .HANDLER_PC(HPC)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .f_valid(f_valid), .f_pc(f_pc), .f_exc(f_exc), .f_cause(f_cause),
        .d_exc(d_exc), .d_cause(d_cause), .e_exc(e_exc), .e_cause(e_cause),
        .m_exc(m_exc), .m_cause(m_cause), .ret_req(ret_req),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .kill_stage(kill_stage), .wb_commit(wb_commit),
        .trap_cause(trap_cause), .trap_epc(trap_epc), .irq_enable(irq_enable)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [XLEN-1:0] exp_epc(input bit irq_hit, input logic [CW-1:0] c,
                                                input logic [XLEN-1:0] pc);
        return (!irq_hit && c == 4'd8) ? pc + 32'd4 : pc;
    endfunction

    // one cycle: drive at falling edge, check, advance the expectation
    task automatic step(input bit fv, input logic [XLEN-1:0] fpc, input bit fe, input logic [CW-1:0] fc,
                        input bit de, input logic [CW-1:0] dc, input bit ee, input logic [CW-1:0] ec,
                        input bit me, input logic [CW-1:0] mcs, input logic [NI-1:0] irq, input bit rr);
        bit d_x, e_x, m_x, irq_hit, trap, ret;
        logic [CW-1:0] d_c, e_c, m_c, ncause;
        logic [XLEN-1:0] nepc;
        f_valid = fv; f_pc = fpc; f_exc = fe; f_cause = fc;
        d_exc = de; d_cause = dc; e_exc = ee; e_cause = ec;
        m_exc = me; m_cause = mcs; irq_lines = irq; ret_req = rr;
        #1;
        d_x = mx[1] | (mv[1] & de); d_c = mx[1] ? mc[1] : dc;
        e_x = mx[2] | (mv[2] & ee); e_c = mx[2] ? mc[2] : ec;
        m_x = mx[3] | (mv[3] & me); m_c = mx[3] ? mc[3] : mcs;
        irq_hit = ien && mv[3] && (irq != 0);
        trap = mv[3] && (irq_hit || m_x);
        ret  = mv[3] && rr && !trap;
        ncause = irq_hit ? 4'd15 : m_c;
        nepc = exp_epc(irq_hit, m_c, mp[3]);
        chk(redirect_valid == (trap || ret), trap ? "R6 redirect" : "R9 redirect", 32'(redirect_valid), 32'(trap || ret));
        if (trap) chk(redirect_pc == HPC, "R6 handler pc", redirect_pc, HPC);
        if (ret)  chk(redirect_pc == eq, "R9 return pc", redirect_pc, eq);
        chk(kill_stage == (trap ? 4'hF : ret ? 4'h7 : 4'h0), "R6/R9 kill", 32'(kill_stage),
            32'(trap ? 4'hF : ret ? 4'h7 : 4'h0));
        chk(wb_commit == (mv[3] && !trap), "R12 wb_commit (R11 younger)", 32'(wb_commit), 32'(mv[3] && !trap));
        chk(trap_cause == cq, "R3 cause", 32'(trap_cause), 32'(cq));
        chk(trap_epc == eq, "R7 epc", trap_epc, eq);
        chk(irq_enable == ien, "R8 irq_enable", 32'(irq_enable), 32'(ien));
        if (trap) begin ien = 1'b0; cq = ncause; eq = nepc; end
        else if (ret) ien = 1'b1;
        if (trap || ret) begin
            for (int i = 1; i <= 3; i++) begin mv[i] = 1'b0; mx[i] = 1'b0; end
        end else begin
            mv[3] = mv[2]; mx[3] = e_x; mc[3] = e_c; mp[3] = mp[2];
            mv[2] = mv[1]; mx[2] = d_x; mc[2] = d_c; mp[2] = mp[1];
            mv[1] = fv;    mx[1] = fv & fe; mc[1] = fc; mp[1] = fpc;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bubble();
        step(0, '0, 0, '0, 0, '0, 0, '0, 0, '0, '0, 0);
    endtask

    // one instruction down the pipe with per-stage faults; irq and ret at its commit
    task automatic insn(input logic [XLEN-1:0] pc, input bit fe, input bit de, input logic [CW-1:0] dc,
                        input bit ee, input bit me, input logic [NI-1:0] irq, input bit rr);
        step(1, pc, fe, 4'd0, 0, '0, 0, '0, 0, '0, irq, 0);
        step(0, '0, 0, '0, de, dc, 0, '0, 0, '0, irq, 0);
        step(0, '0, 0, '0, 0, '0, ee, 4'd12, 0, '0, irq, 0);
        step(0, '0, 0, '0, 0, '0, 0, '0, me, 4'd5, irq, rr);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 1; i <= 3; i++) begin mv[i] = 0; mx[i] = 0; mc[i] = '0; mp[i] = '0; end
        void'($urandom(32'd4417));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(irq_enable == 1'b1, "R1 irq_enable", 32'(irq_enable), 1);
        chk(trap_cause == '0 && trap_epc == '0, "R1 cause/epc", trap_epc, 0);
        chk(!redirect_valid && kill_stage == '0 && !wb_commit, "R1 outputs idle", 32'(kill_stage), 0);
        rst_n = 1'b1;

        // R3 and R2: fetch fault plus execute and memory faults -> fetch cause kept
        insn(32'h100, 1, 0, 4'd0, 1, 1, '0, 0);
        chk(trap_cause == 4'd0, "R3 earliest cause", 32'(trap_cause), 0);
        chk(trap_epc == 32'h100, "R2 fault epc", trap_epc, 32'h100);
        #1;
        // R5: interrupts masked while in handler
        insn(32'h200, 0, 0, 4'd0, 0, 0, 4'hF, 0);
        chk(trap_cause == 4'd0 && trap_epc == 32'h100, "R5 masked irq ignored", trap_epc, 32'h100);
        chk(irq_enable == 1'b0, "R5 still disabled", 32'(irq_enable), 0);
        // R9: return to saved epc and re-enable
        insn(32'h300, 0, 0, 4'd0, 0, 0, '0, 1);
        chk(irq_enable == 1'b1, "R9 re-enabled", 32'(irq_enable), 1);
        // R7: system call epc = pc + 4
        insn(32'h400, 0, 1, 4'd8, 1, 0, '0, 0);
        chk(trap_cause == 4'd8, "R7 syscall cause", 32'(trap_cause), 8);
        chk(trap_epc == 32'h404, "R7 syscall epc", trap_epc, 32'h404);
        insn(32'h500, 0, 0, 4'd0, 0, 0, '0, 1);
        // R10: trap and return together
        insn(32'h600, 0, 0, 4'd0, 0, 1, '0, 1);
        chk(irq_enable == 1'b0, "R10 trap wins", 32'(irq_enable), 0);
        chk(trap_cause == 4'd5 && trap_epc == 32'h600, "R10 cause/epc", trap_epc, 32'h600);
        insn(32'h700, 0, 0, 4'd0, 0, 0, '0, 1);
        // R4: interrupt overrides a synchronous fault
        insn(32'h800, 0, 1, 4'd2, 1, 0, 4'h2, 0);
        chk(trap_cause == 4'd15, "R4 irq cause", 32'(trap_cause), 15);
        chk(trap_epc == 32'h800, "R4 irq epc", trap_epc, 32'h800);
        insn(32'h900, 0, 0, 4'd0, 0, 0, '0, 1);
        // R5: interrupt with empty commit slot has no effect
        step(0, '0, 0, '0, 0, '0, 0, '0, 0, '0, 4'hF, 0);
        chk(irq_enable == 1'b1 && trap_cause == 4'd15, "R5 empty slot", 32'(trap_cause), 15);
        // R11: back-to-back stream, head faults in memory stage
        step(1, 32'hA00, 0, '0, 0, '0, 0, '0, 0, '0, '0, 0);
        step(1, 32'hA04, 0, '0, 0, '0, 0, '0, 0, '0, '0, 0);
        step(1, 32'hA08, 0, '0, 1, 4'd2, 0, '0, 0, '0, '0, 0);
        step(1, 32'hA0C, 0, '0, 0, '0, 1, 4'd12, 1, 4'd5, '0, 0);
        chk(trap_epc == 32'hA00 && trap_cause == 4'd5, "R11 head trapped", trap_epc, 32'hA00);
        repeat (3) bubble();
        chk(trap_epc == 32'hA00, "R11 younger never trap", trap_epc, 32'hA00);

        // random traffic, R12 and the rest checked by the per-step model
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 4) != 0, {$urandom} & 32'hFFFF_FFFC,
                 ($urandom % 16) == 0, 4'd0,
                 ($urandom % 12) == 0, (($urandom % 2) != 0) ? 4'd8 : 4'd2,
                 ($urandom % 12) == 0, 4'd12,
                 ($urandom % 12) == 0, 4'd5,
                 (($urandom % 10) == 0) ? NI'($urandom) : '0,
                 ($urandom % 5) == 0);
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule